// File: doc/BRIEF.md
# Two-Wire Byte-Write Slave Front End

This block is the serial slave front end of a 256-byte register and memory space. It watches the two bus lines (clock and data) and three strap pins that set its sub-address. It pulls the data line low through an open-drain enable when it acknowledges or sends a zero bit. It detects START and STOP conditions, decodes the device address, and acknowledges each byte of a transfer addressed to it. A write transfer is a word address followed by exactly one data byte. It becomes a one-cycle write request to the memory back end only when the master closes the transfer with STOP.

After that request the block runs an internal write timer of `WR_CYCLES` system clocks. While the timer runs, `busy_o` is high and every bus event is ignored, including START. A random read is a write-mode word address, a repeated START, and the device address with the read bit set. It shifts out the byte that the back end returns for that word address. Both bus lines are brought into the system clock domain through two flip-flops, and all edge detection works on the synchronised copies.

Top module: `twi_bytewr_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) starts decoding of a new device address from any state except the busy state. A rising data line while the clock line is high (STOP) ends the transfer.
- R2: The device address byte is taken MSB first as bits [7:4] = 4'b1010, bits [3:1] = sub-address, bit [0] = read (1) or write (0). The block drives `sda_oe_o` high during the ninth clock only when bits [7:4] are 4'b1010 and bits [3:1] equal `strap_i`. Otherwise it gives no acknowledge and ignores the bus until the next START.
- R3: In a write transfer, the word address byte and the data byte are each acknowledged on their ninth clock.
- R4: A STOP that follows an acknowledged data byte raises `wr_req_o` for exactly one cycle, with `wr_addr_o` and `wr_data_o` holding the word address and data byte. This happens at the third system clock edge after the data line rises.
- R5: `busy_o` goes high with `wr_req_o` and stays high for exactly `WR_CYCLES` cycles. During that time the block gives no acknowledge and makes no write, whatever the bus does.
- R6: No write request is made for a STOP that arrives before the data byte is complete. A second data byte in the same transfer is not acknowledged and is not written.
- R7: In a random read, `rd_addr_o` carries the last word address received. The byte on `rd_data_i` is sent MSB first, and each bit changes only after the clock line falls.
- R8: A master NACK after the read byte, followed by STOP, leaves the data line released and makes no write.
- R9: If the master abandons a transfer, clocks until it sees the data line high while the clock line is high, and then issues a START, the next transfer is decoded correctly.
- R10: After reset, `sda_oe_o`, `busy_o` and `wr_req_o` are low.
- R11: `sda_oe_o` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| strap_i | input | 3 | Sub-address strap pins |
| sda_oe_o | output | 1 | High pulls the data line low |
| busy_o | output | 1 | Internal write in progress |
| wr_req_o | output | 1 | One-cycle byte write request |
| wr_addr_o | output | 8 | Word address of the write |
| wr_data_o | output | 8 | Data byte of the write |
| rd_addr_o | output | 8 | Word address presented for reads |
| rd_data_i | input | 8 | Byte returned by the back end for `rd_addr_o` |

## Verification
The assertions assume that each bus clock phase lasts several system clocks. This lets the two-flop synchroniser and the edge detector settle before the bus clock changes again, so a change on `sda_oe_o` lands inside the clock-low phase. They also assume that the data line moves while the clock line is high only to form a START or STOP. The stimulus holds every bus phase for at least eight system clocks. It changes inputs only on falling system clock edges, and it changes the data line only while the clock line is low, except when it forms START and STOP.

// File: rtl/twi_bytewr_slave.sv
module twi_bytewr_slave #(
  parameter int          WR_CYCLES = 200,
  parameter logic [3:0]  DEV_ID    = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       wr_req_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i
);
  localparam int TW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_HOLD, S_RDAT, S_RACK, S_BUSY} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, adr, dat;
  logic       ackph, pend, oe, req;
  logic [TW-1:0] tmr;

  wire scl_s = scl_m[1];
  wire sda_s = sda_m[1];
  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;
  wire rx_st = (st == S_DEV) || (st == S_WADR) || (st == S_WDAT);
  wire match = (sh[7:4] == DEV_ID) && (sh[3:1] == strap_i);

  assign sda_oe_o  = oe;
  assign busy_o    = (st == S_BUSY);
  assign wr_req_o  = req;
  assign wr_addr_o = adr;
  assign wr_data_o = dat;
  assign rd_addr_o = adr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sh    <= '0;
      tx    <= '0;
      adr   <= '0;
      dat   <= '0;
      ackph <= 1'b0;
      pend  <= 1'b0;
      oe    <= 1'b0;
      req   <= 1'b0;
      tmr   <= '0;
    end else begin
      req <= 1'b0;
      if (st == S_BUSY) begin
        if (tmr == '0) st <= S_IDLE;
        else           tmr <= tmr - 1'b1;
      end else if (start) begin
        st    <= S_DEV;
        cnt   <= '0;
        ackph <= 1'b0;
        oe    <= 1'b0;
        pend  <= 1'b0;
      end else if (stop) begin
        oe    <= 1'b0;
        ackph <= 1'b0;
        pend  <= 1'b0;
        if (st == S_HOLD && pend) begin
          st  <= S_BUSY;
          req <= 1'b1;
          tmr <= TW'(WR_CYCLES - 1);
        end else begin
          st <= S_IDLE;
        end
      end else if (rx_st) begin
        if (rise && !ackph && cnt != 4'd8) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 1'b1;
        end else if (fall && !ackph && cnt == 4'd8) begin
          if (st != S_DEV || match) begin
            ackph <= 1'b1;
            oe    <= 1'b1;
            if (st == S_WADR) adr <= sh;
            if (st == S_WDAT) dat <= sh;
          end else begin
            st <= S_IDLE;
          end
        end else if (fall && ackph) begin
          ackph <= 1'b0;
          cnt   <= '0;
          oe    <= 1'b0;
          case (st)
            S_DEV: begin
              if (sh[0]) begin
                st <= S_RDAT;
                tx <= rd_data_i;
                oe <= ~rd_data_i[7];
              end else begin
                st <= S_WADR;
              end
            end
            S_WADR:  st <= S_WDAT;
            default: begin
              st   <= S_HOLD;
              pend <= 1'b1;
            end
          endcase
        end
      end else if (st == S_RDAT) begin
        if (rise) begin
          cnt <= cnt + 1'b1;
        end else if (fall) begin
          if (cnt == 4'd8) begin
            oe <= 1'b0;
            st <= S_RACK;
          end else begin
            tx <= {tx[6:0], 1'b0};
            oe <= ~tx[6];
          end
        end
      end else if (st == S_RACK) begin
        if (rise) st <= S_HOLD;
      end
    end
  end
endmodule

// File: rtl/twi_bytewr_slave_chk.sv
module twi_bytewr_slave_chk #(
  parameter int WR_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy_o,
  input logic wr_req_o
);
  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else        busy_cnt <= busy_o ? busy_cnt + 1 : 0;
  end

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |=> !wr_req_o);

  // R5
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> busy_o);

  // R5
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> wr_req_o);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_cnt == WR_CYCLES);

  // R5
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind twi_bytewr_slave twi_bytewr_slave_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .wr_req_o(wr_req_o)
);

// File: tb/twi_bytewr_slave_tb_top.sv
module twi_bytewr_slave_tb_top;
  localparam int WR = 200;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy, wr_req;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic sda_line;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int cyc = 0, checks = 0, errors = 0;
  int c0 = -100000;
  logic [7:0] exp_a = '0, exp_d = '0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;
  assign rd_data = mem[rd_addr];

  twi_bytewr_slave #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP),
    .sda_oe_o(sda_oe), .busy_o(busy), .wr_req_o(wr_req), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    else if (wr_req) mem[wr_addr] <= wr_data;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model of the write timing, compared on every clock (R4, R5)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_req  = (cyc == c0 + 3);
      automatic bit e_busy = (cyc >= c0 + 3) && (cyc <= c0 + 2 + WR);
      chk(wr_req == e_req, "R4 wr_req", int'(wr_req), int'(e_req));
      chk(busy == e_busy, "R5 busy", int'(busy), int'(e_busy));
      if (e_req) begin
        chk(wr_addr == exp_a, "R4 wr_addr", int'(wr_addr), int'(exp_a));
        chk(wr_data == exp_d, "R4 wr_data", int'(wr_data), int'(exp_d));
      end
    end
  end

  task automatic hc(input int n); repeat (n) @(negedge clk); endtask

  task automatic put_bit(input logic b);
    sda_m = b; hc(6); scl_m = 1'b1; hc(6); scl_m = 1'b0; hc(2);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hc(6); scl_m = 1'b1; hc(3); b = sda_line; hc(3); scl_m = 1'b0; hc(2);
  endtask

  task automatic send_start;
    sda_m = 1'b1; hc(6); scl_m = 1'b1; hc(6); sda_m = 1'b0; hc(6); scl_m = 1'b0; hc(2);
  endtask

  task automatic send_stop(input bit commit);
    sda_m = 1'b0; hc(6); scl_m = 1'b1; hc(6); sda_m = 1'b1;
    if (commit) c0 = cyc;
    hc(6);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int i = 0; i < 8; i++) begin get_bit(b); v = {v[6:0], b}; end
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    bit ack;
    send_start;
    send_byte(dev(STRAP, 1'b0), ack); chk(ack, {tag, " R2 dev ack"}, ack, 1);
    send_byte(a, ack);                chk(ack, {tag, " R3 addr ack"}, ack, 1);
    send_byte(d, ack);                chk(ack, {tag, " R3 data ack"}, ack, 1);
    exp_a = a; exp_d = d; ref_mem[a] = d;
    send_stop(1'b1);
    hc(WR + 10);
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    bit ack;
    logic [7:0] v;
    send_start;
    send_byte(dev(STRAP, 1'b0), ack); chk(ack, {tag, " R2 dev ack"}, ack, 1);
    send_byte(a, ack);                chk(ack, {tag, " R3 addr ack"}, ack, 1);
    send_start;
    send_byte(dev(STRAP, 1'b1), ack); chk(ack, {tag, " R7 read dev ack"}, ack, 1);
    chk(rd_addr == a, {tag, " R7 rd_addr"}, rd_addr, a);
    get_byte(v);
    chk(v == ref_mem[a], {tag, " R7 read data"}, v, ref_mem[a]);
    put_bit(1'b1);
    send_stop(1'b0);
    chk(sda_oe == 1'b0, {tag, " R8 released"}, sda_oe, 0);
    hc(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic b;
    int n;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i) ^ 8'h5A;
    hc(4);
    chk(sda_oe == 0, "R10 oe", sda_oe, 0);
    chk(busy == 0, "R10 busy", busy, 0);
    chk(wr_req == 0, "R10 req", wr_req, 0);
    rst_n = 1'b1;
    hc(10);

    do_write(8'h10, 8'hA5, "basic");
    do_read(8'h10, "rd10");
    do_read(8'h80, "rd80");
    do_write(8'hF9, 8'h3C, "hi");
    do_read(8'hF9, "rdF9");

    // R2 strap mismatch and wrong prefix
    send_start;
    send_byte(dev(STRAP ^ 3'b001, 1'b0), ack); chk(!ack, "R2 strap mismatch ack", ack, 0);
    send_byte(8'h10, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    send_stop(1'b0); hc(10);
    send_start;
    send_byte({4'b1011, STRAP, 1'b0}, ack); chk(!ack, "R2 prefix mismatch ack", ack, 0);
    send_stop(1'b0); hc(10);
    do_read(8'h10, "R2 mem intact");

    // R6 stop before data byte
    send_start;
    send_byte(dev(STRAP, 1'b0), ack);
    send_byte(8'h22, ack);
    send_stop(1'b0); hc(WR + 10);
    do_read(8'h22, "R6 no write");

    // R6 second data byte
    send_start;
    send_byte(dev(STRAP, 1'b0), ack);
    send_byte(8'h30, ack);
    send_byte(8'h11, ack); chk(ack, "R6 first data ack", ack, 1);
    send_byte(8'h99, ack); chk(!ack, "R6 second data ack", ack, 0);
    exp_a = 8'h30; exp_d = 8'h11; ref_mem[8'h30] = 8'h11;
    send_stop(1'b1); hc(WR + 10);
    do_read(8'h30, "R6 first only");

    // R5 bus ignored while busy
    send_start;
    send_byte(dev(STRAP, 1'b0), ack);
    send_byte(8'h40, ack);
    send_byte(8'h77, ack);
    exp_a = 8'h40; exp_d = 8'h77; ref_mem[8'h40] = 8'h77;
    send_stop(1'b1);
    hc(4);
    send_start;
    send_byte(dev(STRAP, 1'b0), ack); chk(!ack, "R5 no ack while busy", ack, 0);
    send_stop(1'b0);
    hc(WR);
    do_read(8'h40, "R5 write done");

    // R1 restart mid-byte
    send_start;
    send_byte(dev(STRAP, 1'b0), ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    do_write(8'h50, 8'hC3, "R1 restart");
    do_read(8'h50, "R1 restart read");
    do_read(8'h60, "R1 aborted untouched");

    // R9 recovery from an abandoned read of a zero byte
    do_write(8'h20, 8'h00, "R9 prep");
    send_start;
    send_byte(dev(STRAP, 1'b0), ack);
    send_byte(8'h20, ack);
    send_start;
    send_byte(dev(STRAP, 1'b1), ack);
    get_bit(b); get_bit(b); get_bit(b);
    n = 0;
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; hc(6); scl_m = 1'b1; hc(3);
      n++;
      if (sda_line) break;
      hc(3); scl_m = 1'b0; hc(2);
    end
    chk(sda_line == 1'b1, "R9 line high within nine clocks", n, 9);
    hc(3); sda_m = 1'b0; hc(6); scl_m = 1'b0; hc(2);
    send_byte(dev(STRAP, 1'b0), ack); chk(ack, "R9 ack after recovery", ack, 1);
    send_byte(8'h21, ack);
    send_byte(8'hE7, ack);
    exp_a = 8'h21; exp_d = 8'hE7; ref_mem[8'h21] = 8'hE7;
    send_stop(1'b1); hc(WR + 10);
    do_read(8'h21, "R9 write after recovery");
    do_read(8'h20, "R9 zero byte kept");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule